// File: doc/BRIEF.md
# SPI Master Data Timing Adjuster

This block sits between an SPI master's shift logic and its pads. It retimes both serial data directions against the internal clock. The outgoing data bit can be held back by zero to three cycles. The incoming data bit can also be delayed by zero to three cycles.

The point at which the incoming bit is captured can be moved relative to the nominal sample strobe. It can sit two cycles early, one cycle early, on the nominal cycle, or one cycle late. Every strobe produces a one-cycle capture-valid pulse together with the captured bit.

Sampling ahead of the strobe works by holding the data path a fixed four cycles behind the input. The strobe is then delayed by two plus the capture code. The valid pulse therefore arrives a fixed number of cycles after the strobe for any given setting.

The three 2-bit codes are read from a 32-bit configuration word. The word is taken into the active settings only in a cycle when no strobe is in flight. The caller is expected to keep strobes away for at least three cycles after a change, so that the input history used for early capture was produced with the new input delay.

Top module: `spi_io_timing_adj`

## Requirements
- R1: After reset all three active codes are zero. `mosi_pad` then equals `mosi_int` in the same cycle, and a strobe in cycle t gives `cap_vld` in cycle t+2.
- R2: The output-delay code in `cfg_word[17:16]`, value k in 0..3, makes `mosi_pad` in cycle n equal `mosi_int` of cycle n-k.
- R3: The input-delay code in `cfg_word[19:18]`, value d in 0..3, makes the captured bit come from `miso_raw` d cycles earlier than it would with d = 0.
- R4: The capture code in `cfg_word[21:20]`, value c in 0..3, captures the input bit of cycle t+c-2 for a strobe in cycle t. So 0 is two early, 1 is one early, 2 is nominal and 3 is one late.
- R5: For a single-cycle strobe in cycle t, `cap_vld` is high in cycle t+2+c and in no other cycle around it.
- R6: With both codes set, `miso_cap` while `cap_vld` is high equals `miso_raw` of cycle t+c-2-d.
- R7: A change of `cfg_word` while a strobe is in flight (on `smp_stb` or inside the strobe pipeline) does not alter that strobe's capture. The new setting takes effect once the pipeline has drained.
- R8: Bits of `cfg_word` outside 21:16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word (delay and capture codes) |
| smp_stb | input | 1 | Nominal sample strobe, one cycle per bit |
| miso_raw | input | 1 | Incoming serial data from the pad |
| mosi_int | input | 1 | Outgoing serial bit from the shifter |
| mosi_pad | output | 1 | Delayed outgoing bit |
| miso_cap | output | 1 | Captured incoming bit, meaningful while `cap_vld` is high |
| cap_vld | output | 1 | One-cycle capture-valid pulse |

## Verification
The bench builds the block with its default 2-bit codes and the 32-bit word layout. At this size all 64 combinations of output delay, input delay and capture code can be swept one after another, each with a pseudo-random data stream and isolated strobes. Expected outputs come from arithmetic on a recorded history of the inputs. This covers every tap of each delay line and every strobe tap, including the early-capture cases that reach back before the strobe. Separate phases check the reset state and a configuration change made while a strobe is in flight.

// File: rtl/spi_io_timing_adj.sv
module spi_io_timing_adj #(
  parameter int CFG_W   = 32,
  parameter int OUT_LSB = 16,
  parameter int IN_LSB  = 18,
  parameter int CAP_LSB = 20,
  parameter int CODE_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             smp_stb,
  input  logic             miso_raw,
  input  logic             mosi_int,
  output logic             mosi_pad,
  output logic             miso_cap,
  output logic             cap_vld
);
  localparam int MAX_DLY  = (1 << CODE_W) - 1;
  localparam int BASE     = 2;
  localparam int NOM_CODE = 2;
  localparam int STB_TAPS = BASE + MAX_DLY;
  localparam int DAT_TAPS = BASE + NOM_CODE;
  localparam int SEL_W    = $clog2(STB_TAPS + 1);

  logic [CODE_W-1:0]   odly_q, idly_q, cap_q;
  logic [MAX_DLY-1:0]  mosi_sr, miso_sr;
  logic [STB_TAPS-1:0] stb_sr;
  logic [DAT_TAPS-1:0] dat_sr;

  logic [MAX_DLY:0]  mosi_taps, miso_taps;
  logic [STB_TAPS:0] stb_taps;
  logic [DAT_TAPS:0] dat_taps;
  logic              miso_dly;
  logic              pending;

  assign mosi_taps = {mosi_sr, mosi_int};
  assign miso_taps = {miso_sr, miso_raw};
  assign mosi_pad  = mosi_taps[odly_q];
  assign miso_dly  = miso_taps[idly_q];
  assign stb_taps  = {stb_sr, smp_stb};
  assign dat_taps  = {dat_sr, miso_dly};
  assign cap_vld   = stb_taps[SEL_W'(BASE) + SEL_W'(cap_q)];
  assign miso_cap  = dat_sr[DAT_TAPS-1];
  assign pending   = smp_stb | (|stb_sr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosi_sr <= '0;
      miso_sr <= '0;
      stb_sr  <= '0;
      dat_sr  <= '0;
    end else begin
      mosi_sr <= mosi_taps[MAX_DLY-1:0];
      miso_sr <= miso_taps[MAX_DLY-1:0];
      stb_sr  <= stb_taps[STB_TAPS-1:0];
      dat_sr  <= dat_taps[DAT_TAPS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odly_q <= '0;
      idly_q <= '0;
      cap_q  <= '0;
    end else if (!pending) begin
      odly_q <= cfg_word[OUT_LSB +: CODE_W];
      idly_q <= cfg_word[IN_LSB  +: CODE_W];
      cap_q  <= cfg_word[CAP_LSB +: CODE_W];
    end
  end
endmodule

// File: rtl/spi_io_timing_chk.sv
module spi_io_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_stb,
  input logic       mosi_int,
  input logic       mosi_pad,
  input logic       cap_vld,
  input logic       pending,
  input logic [1:0] odly,
  input logic [1:0] idly,
  input logic [1:0] cap
);
  AST_VLD_LAT_C0: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == 2'd0 && cap_vld) |-> $past(smp_stb, 2)); // R5
  AST_VLD_LAT_C1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == 2'd1 && cap_vld) |-> $past(smp_stb, 3)); // R5
  AST_VLD_LAT_C2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == 2'd2 && cap_vld) |-> $past(smp_stb, 4)); // R5
  AST_VLD_LAT_C3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == 2'd3 && cap_vld) |-> $past(smp_stb, 5)); // R5
  AST_MOSI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (odly == 2'd1 && $past(odly) == 2'd1) |-> mosi_pad == $past(mosi_int)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable({odly, idly, cap})); // R7
endmodule

bind spi_io_timing_adj spi_io_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mosi_int(mosi_int),
  .mosi_pad(mosi_pad), .cap_vld(cap_vld), .pending(pending),
  .odly(odly_q), .idly(idly_q), .cap(cap_q)
);

// File: tb/sim_spi_io_timing_adj.sv
`timescale 1ns/1ps
module sim_spi_io_timing_adj;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        smp_stb = 1'b0, miso_raw = 1'b0, mosi_int = 1'b0;
  logic        mosi_pad, miso_cap, cap_vld;

  spi_io_timing_adj u0 (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, n = -1;
  int o = 0, d = 0, c = 0;
  bit done = 0;
  string ph = "";
  logic [15:0] lfsr = 16'hACE1;
  logic mh [8192];
  logic ih [8192];
  logic sh [8192];

  function automatic logic hist(int sel, int idx);
    if (idx < 0) return 1'b0;
    case (sel)
      0: return mh[idx];
      1: return ih[idx];
      default: return sh[idx];
    endcase
  endfunction

  task automatic chk1(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d (o=%0d d=%0d c=%0d)",
               tag, act, exp, n, o, d, c);
    end
  endtask

  task automatic step(logic s, bit chk);
    string tm, tv, tb;
    @(negedge clk);
    n++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mosi_int = lfsr[0];
    miso_raw = lfsr[7];
    smp_stb  = s;
    mh[n] = mosi_int; ih[n] = miso_raw; sh[n] = s;
    #1;
    if (chk) begin
      tm = (ph != "") ? ph : "R2/R8";
      tv = (ph != "") ? ph : "R5";
      tb = (ph != "") ? ph : ((d == 0) ? "R4" : ((c == 2) ? "R3" : "R6"));
      chk1(tm, mosi_pad, hist(0, n - o));
      chk1(tv, cap_vld, hist(2, n - 2 - c));
      if (cap_vld) chk1(tb, miso_cap, hist(1, n - 4 - d));
    end
  endtask

  function automatic logic [31:0] mkcfg(int oo, int dd, int cc);
    logic [31:0] w = 32'hFFFF_FFFF;
    w[17:16] = 2'(oo);
    w[19:18] = 2'(dd);
    w[21:20] = 2'(cc);
    return w;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, cfg_word zero
    ph = "R1";
    for (int i = 0; i < 8; i++) step(1'b0, 1);
    step(1'b1, 1);
    for (int i = 0; i < 8; i++) step(1'b0, 1);
    ph = "";
    // Exhaustive sweep of all codes (R2..R6, R8)
    for (int oo = 0; oo < 4; oo++)
      for (int dd = 0; dd < 4; dd++)
        for (int cc = 0; cc < 4; cc++) begin
          cfg_word = mkcfg(oo, dd, cc);
          step(1'b0, 0);
          step(1'b0, 0);
          o = oo; d = dd; c = cc;
          for (int i = 0; i < 5; i++) step(1'b0, 1);
          for (int i = 0; i < 36; i++) step((i % 4) == 0, 1);
          for (int i = 0; i < 7; i++) step(1'b0, 1);
        end
    // R7: change while strobe in flight
    cfg_word = mkcfg(0, 0, 0);
    step(1'b0, 0);
    step(1'b0, 0);
    o = 0; d = 0; c = 0; ph = "R7";
    for (int i = 0; i < 5; i++) step(1'b0, 1);
    step(1'b1, 1);
    cfg_word = mkcfg(0, 0, 3);
    for (int i = 0; i < 8; i++) step(1'b0, 1);
    c = 3;
    for (int i = 0; i < 3; i++) step(1'b0, 1);
    step(1'b1, 1);
    for (int i = 0; i < 8; i++) step(1'b0, 1);
    ph = "";
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule